// File: doc/BRIEF.md
# IDE Channel Register Window Decoder

This block sits between a host I/O port and the task-file of one IDE channel. The host reaches the channel through two windows. One is eight bytes long and holds the data port and the byte-wide task-file registers. The other is four bytes long and holds a single live byte, the alternate-status / device-control register. Each host access gives a window select, an offset, a size code and a direction. The decoder checks the combination, turns a legal access into a one-cycle read or write strobe on the task-file side with the right width and register offset, and returns read data to the host.

Illegal combinations are absorbed. A dropped write leaves the task-file untouched. An illegal read still completes, at the same latency as a legal one, with all ones across the requested width. All data is little-endian, so a byte travels in bits 7:0 and a 16-bit word in bits 15:0.

Top module: `ide_win_decode`

## Requirements
- R1: In the data window (host_win=0), a 1-byte access (host_size=0) at any offset 0..7 produces one task-file strobe with tf_width=0 (byte) and tf_addr equal to the offset.
- R2: In the data window, a 2-byte access (host_size=1) at offset 0 produces one task-file strobe with tf_width=1 (16-bit) and tf_addr=0.
- R3: In the data window, a 4-byte access (host_size=2) at offset 0 produces one task-file strobe with tf_width=2 (32-bit) and tf_addr=0.
- R4: A 2-byte or 4-byte data-window access at a nonzero offset asserts no task-file strobe.
- R5: A read that R4 rejects returns 0x0000FFFF for host_size=1 and 0xFFFFFFFF for host_size=2.
- R6: In the control window (host_win=1), a 1-byte access at offset 2 produces one byte-wide strobe with tf_addr=4. A read returns the alternate status from tf_rdata[7:0], and a write carries the device-control byte.
- R7: Every other control-window access asserts no strobe. Its read returns 0x000000FF, 0x0000FFFF or 0xFFFFFFFF for host_size 0, 1 or 2.
- R8: A strobe is asserted for exactly one cycle, in the cycle after the request. host_rvalid pulses for one cycle, two cycles after a read request, for legal and illegal reads alike, and never follows a write.
- R9: Byte order is little-endian. tf_wdata carries host_wdata limited to the access width with the upper bits zero. A legal read returns tf_rdata limited to the access width with the upper bits zero.
- R10: After reset, tf_rd, tf_wr and host_rvalid are low and host_rdata is zero.
- R11: Size code host_size=3 is reserved. It never asserts a strobe, and its read returns 0xFFFFFFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_req | input | 1 | Host access request, one cycle per access |
| host_wr | input | 1 | 1 = write, 0 = read |
| host_win | input | 1 | 0 = data window, 1 = control window |
| host_off | input | 3 | Byte offset inside the window |
| host_size | input | 2 | 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes, 3 = reserved |
| host_wdata | input | 32 | Write data, little-endian |
| host_rvalid | output | 1 | Read data valid pulse |
| host_rdata | output | 32 | Read data returned to the host |
| tf_rd | output | 1 | Task-file read strobe |
| tf_wr | output | 1 | Task-file write strobe |
| tf_addr | output | 3 | Task-file register offset |
| tf_width | output | 2 | 0 = byte, 1 = 16-bit, 2 = 32-bit |
| tf_wdata | output | 32 | Task-file write data |
| tf_rdata | input | 32 | Task-file read data, valid while tf_rd is high |

## Verification
There are two result points.

- **Strobes:** the task-file strobe, with its address, width and write data, is due one cycle after a request is sampled.
- **Read response:** the host read response is due two cycles after the request, whether the access was legal or absorbed.

The bench drives each request on a falling edge and samples the strobe side one falling edge later, which is also when it withdraws the request. It samples the response side one falling edge after that. Because of this, an early, late or stretched pulse shows up as a mismatch at a fixed sampling point.

// File: rtl/ide_win_pkg.sv
package ide_win_pkg;

  localparam int DW = 32;
  localparam int AW = 3;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_WORD = 2'd1,
    SZ_DWRD = 2'd2,
    SZ_RSVD = 2'd3
  } size_e;

  typedef struct packed {
    logic          legal;
    logic [AW-1:0] addr;
    logic [1:0]    width;
  } dec_t;

  localparam logic [AW-1:0] CTRL_LIVE_OFF = 3'd2;
  localparam logic [AW-1:0] CTRL_TF_ADDR  = 3'd4;

  function automatic logic [DW-1:0] lane_mask(input logic [1:0] sz);
    case (sz)
      SZ_BYTE: lane_mask = 32'h0000_00FF;
      SZ_WORD: lane_mask = 32'h0000_FFFF;
      default: lane_mask = 32'hFFFF_FFFF;
    endcase
  endfunction

endpackage

// File: rtl/ide_win_legal.sv
module ide_win_legal
  import ide_win_pkg::*;
(
  input  logic          win,
  input  logic [AW-1:0] off,
  input  logic [1:0]    size,
  output dec_t          dec
);

  always_comb begin
    dec = '0;
    if (!win) begin
      if (size == SZ_BYTE) begin
        dec.legal = 1'b1;
        dec.addr  = off;
        dec.width = SZ_BYTE;
      end else if ((size == SZ_WORD || size == SZ_DWRD) && off == '0) begin
        dec.legal = 1'b1;
        dec.addr  = '0;
        dec.width = size;
      end
    end else begin
      if (size == SZ_BYTE && off == CTRL_LIVE_OFF) begin
        dec.legal = 1'b1;
        dec.addr  = CTRL_TF_ADDR;
        dec.width = SZ_BYTE;
      end
    end
  end

endmodule

// File: rtl/ide_win_issue.sv
module ide_win_issue
  import ide_win_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req,
  input  logic          wr,
  input  logic [1:0]    size,
  input  logic [DW-1:0] wdata,
  input  dec_t          dec,
  output logic          tf_rd,
  output logic          tf_wr,
  output logic [AW-1:0] tf_addr,
  output logic [1:0]    tf_width,
  output logic [DW-1:0] tf_wdata,
  output logic          pend_rd,
  output logic          pend_ill,
  output logic [1:0]    pend_size
);

  logic          rd_d, wr_d, prd_d, pill_d;
  logic [AW-1:0] addr_d;
  logic [1:0]    width_d, psize_d;
  logic [DW-1:0] wdata_d;
  logic          load_en;

  assign load_en = req && dec.legal;

  always_comb begin
    rd_d    = req && !wr && dec.legal;
    wr_d    = req &&  wr && dec.legal;
    prd_d   = req && !wr;
    pill_d  = req && !wr && !dec.legal;
    psize_d = size;
    addr_d  = dec.addr;
    width_d = dec.width;
    wdata_d = wdata & lane_mask(dec.width);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tf_rd     <= 1'b0;
      tf_wr     <= 1'b0;
      pend_rd   <= 1'b0;
      pend_ill  <= 1'b0;
      pend_size <= '0;
      tf_addr   <= '0;
      tf_width  <= '0;
      tf_wdata  <= '0;
    end else begin
      tf_rd    <= rd_d;
      tf_wr    <= wr_d;
      pend_rd  <= prd_d;
      pend_ill <= pill_d;
      if (req) pend_size <= psize_d;
      if (load_en) begin
        tf_addr  <= addr_d;
        tf_width <= width_d;
        tf_wdata <= wdata_d;
      end
    end
  end

  AST_ONE_DIR: assert property (@(posedge clk) disable iff (!rst_n)
    !(tf_rd && tf_wr)) else $error("read and write strobe together"); // R8
  AST_WIDE_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    ((tf_rd || tf_wr) && tf_width != SZ_BYTE) |-> tf_addr == '0)
    else $error("wide transfer off the data port"); // R4
  AST_NO_RSVD_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
    (tf_rd || tf_wr) |-> tf_width != SZ_RSVD)
    else $error("reserved width strobed"); // R11

endmodule

// File: rtl/ide_win_resp.sv
module ide_win_resp
  import ide_win_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pend_rd,
  input  logic          pend_ill,
  input  logic [1:0]    pend_size,
  input  logic [1:0]    tf_width,
  input  logic [DW-1:0] tf_rdata,
  output logic          rvalid,
  output logic [DW-1:0] rdata
);

  logic          rvalid_d;
  logic [DW-1:0] rdata_d;

  always_comb begin
    rvalid_d = pend_rd;
    if (pend_ill) rdata_d = lane_mask(pend_size);
    else          rdata_d = tf_rdata & lane_mask(tf_width);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rvalid <= 1'b0;
      rdata  <= '0;
    end else begin
      rvalid <= rvalid_d;
      if (pend_rd) rdata <= rdata_d;
    end
  end

  AST_FILL_ONES: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_rd && pend_ill && pend_size != SZ_BYTE) |=> rdata[15:0] == 16'hFFFF)
    else $error("absorbed read not all ones"); // R5

endmodule

// File: rtl/ide_win_decode.sv
module ide_win_decode
  import ide_win_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          host_req,
  input  logic          host_wr,
  input  logic          host_win,
  input  logic [2:0]    host_off,
  input  logic [1:0]    host_size,
  input  logic [31:0]   host_wdata,
  output logic          host_rvalid,
  output logic [31:0]   host_rdata,
  output logic          tf_rd,
  output logic          tf_wr,
  output logic [2:0]    tf_addr,
  output logic [1:0]    tf_width,
  output logic [31:0]   tf_wdata,
  input  logic [31:0]   tf_rdata
);

  dec_t       dec;
  logic       pend_rd, pend_ill;
  logic [1:0] pend_size;

  ide_win_legal u_legal (
    .win  (host_win),
    .off  (host_off),
    .size (host_size),
    .dec  (dec)
  );

  ide_win_issue u_issue (
    .clk       (clk),
    .rst_n     (rst_n),
    .req       (host_req),
    .wr        (host_wr),
    .size      (host_size),
    .wdata     (host_wdata),
    .dec       (dec),
    .tf_rd     (tf_rd),
    .tf_wr     (tf_wr),
    .tf_addr   (tf_addr),
    .tf_width  (tf_width),
    .tf_wdata  (tf_wdata),
    .pend_rd   (pend_rd),
    .pend_ill  (pend_ill),
    .pend_size (pend_size)
  );

  ide_win_resp u_resp (
    .clk       (clk),
    .rst_n     (rst_n),
    .pend_rd   (pend_rd),
    .pend_ill  (pend_ill),
    .pend_size (pend_size),
    .tf_width  (tf_width),
    .tf_rdata  (tf_rdata),
    .rvalid    (host_rvalid),
    .rdata     (host_rdata)
  );

  AST_STROBE_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (tf_rd || tf_wr) |-> $past(host_req)) else $error("strobe without request"); // R8
  AST_RESP_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    host_rvalid |-> $past(host_req && !host_wr, 2))
    else $error("response at wrong latency"); // R8
  AST_CTRL_MAP: assert property (@(posedge clk) disable iff (!rst_n)
    ((tf_rd || tf_wr) && $past(host_win)) |-> (tf_addr == 3'd4 && tf_width == 2'd0))
    else $error("control access mis-mapped"); // R6

endmodule

// File: tb/ide_win_decode_tb_top.sv
module ide_win_decode_tb_top;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        host_req, host_wr, host_win;
  logic [2:0]  host_off;
  logic [1:0]  host_size;
  logic [31:0] host_wdata;
  logic        host_rvalid;
  logic [31:0] host_rdata;
  logic        tf_rd, tf_wr;
  logic [2:0]  tf_addr;
  logic [1:0]  tf_width;
  logic [31:0] tf_wdata;
  logic [31:0] tf_rdata;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #10 clk = ~clk;

  // task-file model: data depends on the register addressed
  assign tf_rdata = 32'hC4B3_A200 + {29'd0, tf_addr} * 32'h0101_0111;

  ide_win_decode dut_i (
    .clk, .rst_n, .host_req, .host_wr, .host_win, .host_off, .host_size,
    .host_wdata, .host_rvalid, .host_rdata, .tf_rd, .tf_wr, .tf_addr,
    .tf_width, .tf_wdata, .tf_rdata
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mask_of(input int sz);
    return (sz == 0) ? 32'hFF : (sz == 1) ? 32'hFFFF : 32'hFFFF_FFFF;
  endfunction

  task automatic access(input bit wr, input bit win, input int off, input int sz,
                        input logic [31:0] wd);
    bit          legal;
    int          eaddr;
    logic [31:0] emodel;
    string       tag;
    legal = 1'b0;
    eaddr = off;
    if (!win) begin
      if (sz == 0) legal = 1'b1;
      else if ((sz == 1 || sz == 2) && off == 0) legal = 1'b1;
    end else if (sz == 0 && off == 2) begin
      legal = 1'b1;
      eaddr = 4;
    end
    if (sz == 3) tag = "R11";
    else if (win) tag = legal ? "R6" : "R7";
    else if (sz == 0) tag = "R1";
    else if (off != 0) tag = wr ? "R4" : "R5";
    else tag = (sz == 1) ? "R2" : "R3";

    @(negedge clk);
    host_req = 1'b1; host_wr = wr; host_win = win;
    host_off = 3'(off); host_size = 2'(sz); host_wdata = wd;
    @(negedge clk);
    host_req = 1'b0;
    chk(tf_rd == (legal && !wr), tag, {31'd0, tf_rd}, {31'd0, legal && !wr});
    chk(tf_wr == (legal && wr), tag, {31'd0, tf_wr}, {31'd0, legal && wr});
    if (legal) begin
      chk(tf_addr == 3'(eaddr), tag, {29'd0, tf_addr}, eaddr);
      chk(tf_width == 2'(sz), tag, {30'd0, tf_width}, sz);
      if (wr) chk(tf_wdata == (wd & mask_of(sz)), "R9", tf_wdata, wd & mask_of(sz));
    end
    emodel = 32'hC4B3_A200 + eaddr * 32'h0101_0111;
    @(negedge clk);
    chk(!tf_rd && !tf_wr, "R8", {30'd0, tf_rd, tf_wr}, 0);
    chk(host_rvalid == !wr, "R8", {31'd0, host_rvalid}, {31'd0, !wr});
    if (!wr) begin
      if (legal)
        chk(host_rdata == (emodel & mask_of(sz)), legal && win ? "R6" : "R9",
            host_rdata, emodel & mask_of(sz));
      else
        chk(host_rdata == mask_of(sz), tag, host_rdata, mask_of(sz));
    end
    @(negedge clk);
    chk(!host_rvalid, "R8", {31'd0, host_rvalid}, 0);
  endtask

  initial begin
    host_req = 1'b0; host_wr = 1'b0; host_win = 1'b0;
    host_off = '0; host_size = '0; host_wdata = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(!tf_rd && !tf_wr && !host_rvalid, "R10", {29'd0, tf_rd, tf_wr, host_rvalid}, 0);
    chk(host_rdata == 32'd0, "R10", host_rdata, 0);
    rst_n = 1'b1;
    for (int w = 0; w < 2; w++)
      for (int o = 0; o < 8; o++)
        for (int s = 0; s < 4; s++)
          for (int d = 0; d < 2; d++)
            access(d[0], w[0], o, s, 32'h8899_AABB ^ (o * 32'h1357_9BDF) ^ (s << 20));
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog act=0 exp=1");
      end
    join_any
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule